// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock timing of an I2C master. It counts ticks of the internal operating clock against four programmed counts: the whole SCL period, the SCL low time, the setup time ahead of a repeated start or stop, and the data setup time ahead of each SCL rise. The byte engine next to it asks for clocks with `clk_req_i`. It gets back single-cycle strobes for the SCL falling and rising edges, the point where SDA may change, and the point where a start or stop condition may be placed on SDA. The rising-edge strobe is also the SDA sample point. The defaults suit a 50 MHz internal clock and a 400 kHz bus, which is the fastest rate supported.

A bus-reset control word gates the block. Bit 1 enables normal operation. Bit 0 releases SCL when normal operation is off. While normal operation is off, SCL is held low unless it has been released, no strobes are produced, and the four timing counts can be written. While normal operation is on, the counts are locked. While SCL is in its high phase, the high-time counter counts only the ticks in which the line actually reads high. A target that stretches the clock therefore lengthens the period.

Top module: `scl_tim_gen`

## Requirements
- R1: After reset, normal operation is off and SCL is not released, so `scl_low_o` is 1 and no strobe is active. The counts start at 125 (period), 62 (low), 62 (condition setup) and 7 (data setup). With no writes, enabling normal operation gives falling edges every 125 ticks.
- R2: The bus-reset word is written through `brst_wr_en`/`brst_wr_data`, with bit 1 as normal-operation enable and bit 0 as SCL release. While bit 1 is 0, `scl_low_o` equals the inverse of bit 0 and every strobe stays 0, whatever `clk_req_i` does.
- R3: A timing write selects its count with `tim_wr_addr`: 0 is the period, 1 is the low time, 2 is the condition setup and 3 is the data setup. A write made while normal operation is on has no effect.
- R4: When idle and enabled with `clk_req_i` high, `scl_fall_o` pulses in that same cycle. While the request stays high, it pulses again every period-count ticks.
- R5: `scl_low_o` is 1 for exactly low-count cycles, starting the cycle after `scl_fall_o`. `scl_rise_o` pulses in the last of those cycles. A low count of 0 acts as 1.
- R6: `sda_chg_o` pulses in the low cycle that leaves exactly data-setup cycles of the low phase, counting that cycle itself. If the data setup is not less than the low count, it pulses in the first low cycle instead.
- R7: With `cond_req_i` high, `cond_pt_o` pulses on the S-th counted high tick, where S is the condition-setup count. S is limited to the high time (period minus low), and an S of 0 acts as 1.
- R8: While `scl_in_i` reads 0 during the high phase, the high counter stalls. Each stalled cycle delays the next falling edge by one cycle.
- R9: If `clk_req_i` is 0 when the high phase ends, no falling edge is produced. The block goes idle with SCL released.
- R10: Clearing normal operation in the middle of a transfer drops the block to idle in the next cycle. The next request after re-enabling starts with an immediate falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal operating clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tim_wr_en | input | 1 | Timing count write strobe |
| tim_wr_addr | input | 2 | Timing count select |
| tim_wr_data | input | CW | Timing count value |
| brst_wr_en | input | 1 | Bus-reset word write strobe |
| brst_wr_data | input | 2 | Bus-reset word: bit 1 enable, bit 0 SCL release |
| clk_req_i | input | 1 | Engine requests SCL clocks |
| cond_req_i | input | 1 | Engine wants a start/stop placement point |
| scl_in_i | input | 1 | Sensed SCL line level |
| scl_low_o | output | 1 | Drive SCL low |
| scl_fall_o | output | 1 | SCL falling-edge strobe |
| scl_rise_o | output | 1 | SCL rising-edge and SDA sample strobe |
| sda_chg_o | output | 1 | SDA may change now |
| cond_pt_o | output | 1 | Start/stop condition may be placed now |

## Verification
Two pairs of strobes can land in the same cycle. When the data setup equals 1, the SDA change point falls in the same cycle as the rising edge. When the condition setup reaches or exceeds the high time, the condition point falls in the same cycle as the next falling edge. A sweep over all small low, period, data-setup and condition-setup combinations produces both coincidences. It also covers their clamped forms. The bench compares every strobe in every cycle against positions computed arithmetically from the counts, so a strobe that is lost or moved when two coincide is reported.

// File: rtl/scl_tim_pkg.sv
// Package: shared phase encoding and timing-count select codes for the
// SCL timing generator. Assumes a two-bit select on the timing write port.
package scl_tim_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    localparam logic [1:0] SEL_PERIOD = 2'd0;
    localparam logic [1:0] SEL_LOW    = 2'd1;
    localparam logic [1:0] SEL_CONDSU = 2'd2;
    localparam logic [1:0] SEL_DATASU = 2'd3;

endpackage

// File: rtl/scl_tim_cfg.sv
// Module: holds the four timing counts and the bus-reset word.
// Timing counts are writable only while normal operation is disabled.
// Assumes writes arrive as single-cycle strobes in the clk domain.
module scl_tim_cfg
    import scl_tim_pkg::*;
#(
    parameter int CW       = 10,
    parameter int RST_PER  = 125,
    parameter int RST_LOW  = 62,
    parameter int RST_CSU  = 62,
    parameter int RST_DSU  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tim_wr_en,
    input  logic [1:0]    tim_wr_addr,
    input  logic [CW-1:0] tim_wr_data,
    input  logic          brst_wr_en,
    input  logic [1:0]    brst_wr_data,
    output logic [CW-1:0] per_cnt,
    output logic [CW-1:0] low_cnt,
    output logic [CW-1:0] csu_cnt,
    output logic [CW-1:0] dsu_cnt,
    output logic          run,
    output logic          rel
);

    logic          run_q, rel_q;
    logic [CW-1:0] per_q, low_q, csu_q, dsu_q;
    logic          tim_open;

    assign tim_open = tim_wr_en && !run_q;

    // Bus-reset word: enable and release bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            rel_q <= 1'b0;
        end else if (brst_wr_en) begin
            run_q <= brst_wr_data[1];
            rel_q <= brst_wr_data[0];
        end
    end

    // Timing counts, updated only while normal operation is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= CW'(RST_PER);
            low_q <= CW'(RST_LOW);
            csu_q <= CW'(RST_CSU);
            dsu_q <= CW'(RST_DSU);
        end else if (tim_open) begin
            case (tim_wr_addr)
                SEL_PERIOD: per_q <= tim_wr_data;
                SEL_LOW:    low_q <= tim_wr_data;
                SEL_CONDSU: csu_q <= tim_wr_data;
                default:    dsu_q <= tim_wr_data;
            endcase
        end
    end

    assign per_cnt = per_q;
    assign low_cnt = low_q;
    assign csu_cnt = csu_q;
    assign dsu_cnt = dsu_q;
    assign run     = run_q;
    assign rel     = rel_q;

    assert_locked_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> ($stable(per_q) && $stable(low_q) && $stable(csu_q) && $stable(dsu_q)));

endmodule

// File: rtl/scl_tim_pts.sv
// Module: turns the raw counts into terminal and event counter values,
// clamping degenerate settings so every point lies inside its phase.
// Purely combinational; assumes counts are stable while running.
module scl_tim_pts #(
    parameter int CW = 10
) (
    input  logic [CW-1:0] per_cnt,
    input  logic [CW-1:0] low_cnt,
    input  logic [CW-1:0] csu_cnt,
    input  logic [CW-1:0] dsu_cnt,
    output logic [CW-1:0] lo_last,
    output logic [CW-1:0] hi_last,
    output logic [CW-1:0] chg_pt,
    output logic [CW-1:0] su_pt
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] lo_eff, hi_eff;

    // Effective phase lengths: low at least 1, high at least 1.
    always_comb begin
        lo_eff = (low_cnt == '0) ? ONE : low_cnt;
        hi_eff = (per_cnt > lo_eff) ? (per_cnt - lo_eff) : ONE;
    end

    // Event positions within each phase.
    always_comb begin
        lo_last = lo_eff - ONE;
        hi_last = hi_eff - ONE;
        chg_pt  = (dsu_cnt >= lo_eff) ? '0 : (lo_eff - dsu_cnt);
        if (csu_cnt == '0)
            su_pt = '0;
        else if (csu_cnt >= hi_eff)
            su_pt = hi_eff - ONE;
        else
            su_pt = csu_cnt - ONE;
    end

endmodule

// File: rtl/scl_tim_seq.sv
// Module: phase sequencer. One counter serves both SCL phases; the high
// phase only counts ticks where the sensed line is high. Strobes are
// decoded from the registered phase and counter in the same cycle.
// Assumes scl_in already synchronised to clk.
module scl_tim_seq
    import scl_tim_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          rel,
    input  logic          clk_req,
    input  logic          cond_req,
    input  logic          scl_in,
    input  logic [CW-1:0] lo_last,
    input  logic [CW-1:0] hi_last,
    input  logic [CW-1:0] chg_pt,
    input  logic [CW-1:0] su_pt,
    output logic          scl_low,
    output logic          fall_stb,
    output logic          rise_stb,
    output logic          chg_stb,
    output logic          cond_stb
);

    scl_phase_e    ph_q;
    logic [CW-1:0] cnt_q;
    logic          hi_tick, lo_end, hi_end;

    // Phase-end and tick decode.
    always_comb begin
        hi_tick = (ph_q == PH_HIGH) && scl_in;
        lo_end  = (ph_q == PH_LOW) && (cnt_q == lo_last);
        hi_end  = hi_tick && (cnt_q == hi_last);
    end

    // Strobes and SCL drive.
    always_comb begin
        fall_stb = run && clk_req && ((ph_q == PH_IDLE) || hi_end);
        rise_stb = run && lo_end;
        chg_stb  = run && (ph_q == PH_LOW) && (cnt_q == chg_pt);
        cond_stb = run && cond_req && hi_tick && (cnt_q == su_pt);
        scl_low  = run ? (ph_q == PH_LOW) : !rel;
    end

    // Phase and counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (clk_req) ph_q <= PH_LOW;
                end
                PH_LOW: begin
                    if (lo_end) begin
                        ph_q  <= PH_HIGH;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                PH_HIGH: begin
                    if (hi_end) begin
                        ph_q  <= clk_req ? PH_LOW : PH_IDLE;
                        cnt_q <= '0;
                    end else if (hi_tick) begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: begin
                    ph_q  <= PH_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assert_fall_opens_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> (ph_q == PH_LOW && cnt_q == '0));

    assert_rise_opens_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> (ph_q == PH_HIGH && cnt_q == '0));

    assert_stretch_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ph_q == PH_HIGH && !scl_in) |=> (cnt_q == $past(cnt_q)));

    assert_disable_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (ph_q == PH_IDLE));

endmodule

// File: rtl/scl_tim_gen.sv
// Module: top of the SCL timing generator. Wires configuration, point
// decode and the phase sequencer. Assumes one clock domain and an
// externally synchronised SCL sense input.
module scl_tim_gen #(
    parameter int CW      = 10,
    parameter int RST_PER = 125,
    parameter int RST_LOW = 62,
    parameter int RST_CSU = 62,
    parameter int RST_DSU = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tim_wr_en,
    input  logic [1:0]    tim_wr_addr,
    input  logic [CW-1:0] tim_wr_data,
    input  logic          brst_wr_en,
    input  logic [1:0]    brst_wr_data,
    input  logic          clk_req_i,
    input  logic          cond_req_i,
    input  logic          scl_in_i,
    output logic          scl_low_o,
    output logic          scl_fall_o,
    output logic          scl_rise_o,
    output logic          sda_chg_o,
    output logic          cond_pt_o
);

    logic [CW-1:0] per_cnt, low_cnt, csu_cnt, dsu_cnt;
    logic [CW-1:0] lo_last, hi_last, chg_pt, su_pt;
    logic          run, rel;

    scl_tim_cfg #(
        .CW(CW), .RST_PER(RST_PER), .RST_LOW(RST_LOW),
        .RST_CSU(RST_CSU), .RST_DSU(RST_DSU)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .tim_wr_en(tim_wr_en), .tim_wr_addr(tim_wr_addr), .tim_wr_data(tim_wr_data),
        .brst_wr_en(brst_wr_en), .brst_wr_data(brst_wr_data),
        .per_cnt(per_cnt), .low_cnt(low_cnt), .csu_cnt(csu_cnt), .dsu_cnt(dsu_cnt),
        .run(run), .rel(rel)
    );

    scl_tim_pts #(.CW(CW)) u_pts (
        .per_cnt(per_cnt), .low_cnt(low_cnt), .csu_cnt(csu_cnt), .dsu_cnt(dsu_cnt),
        .lo_last(lo_last), .hi_last(hi_last), .chg_pt(chg_pt), .su_pt(su_pt)
    );

    scl_tim_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .rel(rel),
        .clk_req(clk_req_i), .cond_req(cond_req_i), .scl_in(scl_in_i),
        .lo_last(lo_last), .hi_last(hi_last), .chg_pt(chg_pt), .su_pt(su_pt),
        .scl_low(scl_low_o), .fall_stb(scl_fall_o), .rise_stb(scl_rise_o),
        .chg_stb(sda_chg_o), .cond_stb(cond_pt_o)
    );

    assert_chg_while_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_chg_o |-> scl_low_o);

    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !brst_wr_en |=> (!run -> !(scl_fall_o || scl_rise_o || sda_chg_o || cond_pt_o)));

endmodule

// File: tb/scl_tim_gen_bench.sv
module scl_tim_gen_bench;

    localparam int CLK_P = 10;
    localparam int CW    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tim_wr_en = 1'b0;
    logic [1:0]    tim_wr_addr = 2'd0;
    logic [CW-1:0] tim_wr_data = '0;
    logic          brst_wr_en = 1'b0;
    logic [1:0]    brst_wr_data = 2'd0;
    logic          clk_req = 1'b0;
    logic          cond_req = 1'b0;
    logic          stretch = 1'b0;
    logic          scl_line;
    logic          scl_low, fall, rise, chg, cond;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    assign scl_line = !(scl_low || stretch);

    always #(CLK_P/2) clk = ~clk;

    scl_tim_gen u_scl_tim_gen (
        .clk(clk), .rst_n(rst_n),
        .tim_wr_en(tim_wr_en), .tim_wr_addr(tim_wr_addr), .tim_wr_data(tim_wr_data),
        .brst_wr_en(brst_wr_en), .brst_wr_data(brst_wr_data),
        .clk_req_i(clk_req), .cond_req_i(cond_req), .scl_in_i(scl_line),
        .scl_low_o(scl_low), .scl_fall_o(fall), .scl_rise_o(rise),
        .sda_chg_o(chg), .cond_pt_o(cond)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr_ctl(input logic [1:0] d);
        @(posedge clk); #1;
        brst_wr_en = 1'b1; brst_wr_data = d;
        @(posedge clk); #1;
        brst_wr_en = 1'b0;
    endtask

    task automatic wr_tim(input logic [1:0] a, input int d);
        @(posedge clk); #1;
        tim_wr_en = 1'b1; tim_wr_addr = a; tim_wr_data = CW'(d);
        @(posedge clk); #1;
        tim_wr_en = 1'b0;
    endtask

    // Runs 3 periods with request held and checks every strobe per cycle.
    task automatic check_run(input int lo, input int per, input int dsu, input int csu);
        int le, hi, cp, sp, pos, m;
        le  = (lo == 0) ? 1 : lo;
        hi  = per - le;
        cp  = (dsu >= le) ? 0 : le - dsu;
        sp  = (csu == 0) ? 0 : ((csu >= hi) ? hi - 1 : csu - 1);
        pos = le + 1 + sp;
        for (int i = 0; i < 3 * per; i++) begin
            @(posedge clk); #1;
            clk_req = 1'b1; cond_req = 1'b1;
            @(negedge clk);
            m = i % per;
            check("R4 fall", int'(fall), int'(m == 0));
            check("R5 scl_low", int'(scl_low), int'(m >= 1 && m <= le));
            check("R5 rise", int'(rise), int'(m == le));
            check("R6 sda_chg", int'(chg), int'(m == 1 + cp));
            check("R7 cond", int'(cond), int'(i >= pos && ((i - pos) % per) == 0));
        end
        @(posedge clk); #1;
        clk_req = 1'b0; cond_req = 1'b0;
    endtask

    task automatic setup(input int lo, input int per, input int dsu, input int csu);
        wr_ctl(2'b01);
        wr_tim(2'd0, per);
        wr_tim(2'd1, lo);
        wr_tim(2'd2, csu);
        wr_tim(2'd3, dsu);
        wr_ctl(2'b11);
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1 scl_low", int'(scl_low), 1);
        check("R1 strobes", int'(fall | rise | chg | cond), 0);

        // R1: default counts give 125-tick period, rise at 62
        wr_ctl(2'b11);
        for (int i = 0; i < 130; i++) begin
            @(posedge clk); #1 clk_req = 1'b1;
            @(negedge clk);
            check("R1 default fall", int'(fall), int'(i % 125 == 0));
            check("R1 default rise", int'(rise), int'(i % 125 == 62));
        end
        @(posedge clk); #1 clk_req = 1'b0;

        // R2: disabled and released: no strobes, SCL free
        wr_ctl(2'b01);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1 clk_req = 1'b1; cond_req = 1'b1;
            @(negedge clk);
            check("R2 released scl_low", int'(scl_low), 0);
            check("R2 released strobes", int'(fall | rise | chg | cond), 0);
        end
        wr_ctl(2'b00);
        @(negedge clk);
        check("R2 held scl_low", int'(scl_low), 1);
        check("R2 held strobes", int'(fall | rise | chg | cond), 0);
        @(posedge clk); #1 clk_req = 1'b0; cond_req = 1'b0;

        // R4..R7: sweep over small configurations
        for (int lo = 0; lo <= 4; lo++) begin
            for (int dp = 1; dp <= 4; dp++) begin
                int le, per;
                le  = (lo == 0) ? 1 : lo;
                per = le + dp;
                for (int dsu = 1; dsu <= le + 1; dsu++) begin
                    for (int csu = 1; csu <= dp + 1; csu++) begin
                        setup(lo, per, dsu, csu);
                        check_run(lo, per, dsu, csu);
                    end
                end
            end
        end

        // R3: writes while running are ignored
        setup(2, 5, 1, 1);
        wr_tim(2'd0, 9);
        wr_tim(2'd1, 4);
        wr_tim(2'd3, 3);
        check_run(2, 5, 1, 1);

        // R8: stretch during the first high phase for 3 cycles
        setup(2, 5, 1, 1);
        for (int i = 0; i < 15; i++) begin
            @(posedge clk); #1;
            clk_req = 1'b1;
            stretch = (i >= 3 && i < 6);
            @(negedge clk);
            check("R8 fall", int'(fall), int'(i == 0 || i == 8 || i == 13));
            check("R8 rise", int'(rise), int'(i == 2 || i == 10));
        end
        @(posedge clk); #1 clk_req = 1'b0; stretch = 1'b0;

        // R9: request dropped, no further falling edge
        setup(2, 5, 1, 1);
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            clk_req = (i <= 2);
            @(negedge clk);
            check("R9 fall", int'(fall), int'(i == 0));
            check("R9 scl_low", int'(scl_low), int'(i == 1 || i == 2));
        end

        // R10: disable mid-transfer, then re-enable
        setup(2, 5, 1, 1);
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            clk_req = 1'b1;
            brst_wr_en   = (i == 2 || i == 6);
            brst_wr_data = (i == 6) ? 2'b11 : 2'b01;
            @(negedge clk);
            if (i >= 3 && i <= 6) begin
                check("R10 off scl_low", int'(scl_low), 0);
                check("R10 off fall", int'(fall), 0);
            end
            if (i == 7) check("R10 restart fall", int'(fall), 1);
            if (i == 8) check("R10 restart scl_low", int'(scl_low), 1);
        end
        @(posedge clk); #1;
        brst_wr_en = 1'b0; clk_req = 1'b0;

        done = 1'b1;
        finish_up();
    end

endmodule